// File: doc/BRIEF.md
# Link Receive Sequence Checker

This block sits on the receive side of a reliable packet link. Packets arrive as a stream of 32-bit words. The first word is a header whose low 12 bits hold the packet's sequence number. The last word is a CRC-32 that covers every word before it. The block stores the header and payload while it runs the CRC. At the closing word it decides what to do with the packet. A packet is accepted only if its check value matches and its sequence number is the one expected next. An accepted packet is forwarded, header first, to the upper layer over a valid/ready stream. After the packet is judged, the block raises a one-cycle request for either a positive or a negative acknowledgement, together with a sequence number.

Acceptance is strictly in order, to suit a transmitter that replays with go-back-N. A corrupted, malformed or out-of-order packet produces one negative acknowledgement. That acknowledgement carries the sequence number from which the transmitter must resend. After it, every later packet is dropped silently until the expected number arrives intact. A replayed copy of the most recently accepted packet is dropped but still acknowledged, so that the transmitter can retire it.

Top module: `link_rx_seq_check`

## Requirements
- R1: After reset the expected sequence number is 0 and no negative acknowledgement is pending. `in_ready` is 1, and `out_valid`, `ack_req` and `nak_req` are 0.
- R2: The check value is CRC-32 with the reflected polynomial 0xEDB88320, a start value of all ones and a final inversion. It runs over the header and payload words, and the bytes of each word are taken from bits 7:0 upward. A packet whose last word differs from this value is bad.
- R3: A packet is accepted when its CRC is good and its header bits 11:0 equal the expected number. The cycle after the last beat, `ack_req` pulses with that number. From the same cycle the header and payload words appear on the output in arrival order, and `out_last` marks the final word.
- R4: Each accepted packet advances the expected number by one, modulo 4096, so 4095 is followed by 0. Discarded packets leave it unchanged.
- R5: When no negative acknowledgement is pending, a packet with a bad CRC makes `nak_req` pulse the cycle after its last beat, with `nak_seq` equal to the expected number. Nothing is forwarded.
- R6: A packet with a good CRC whose number is neither the expected number nor the one below it is treated like a CRC failure. It is answered as in R5 and is not forwarded.
- R7: Once a negative acknowledgement has been sent, no further one is issued and nothing is forwarded until a packet with the expected number is accepted.
- R8: A packet with a good CRC whose number is one below the expected number (modulo 4096) is not forwarded. It is answered with an `ack_req` pulse carrying that number, whether or not a negative acknowledgement is pending, and it leaves the pending state unchanged.
- R9: A packet is malformed, and is handled as a CRC failure, in two cases: it has a single beat (first and last together), or it has more than DEPTH (8) words before its CRC word.
- R10: `in_ready` is 0 while a packet is being forwarded. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_last` hold.
- R11: `ack_req` and `nak_req` are never 1 in the same cycle, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming word is present |
| in_ready | output | 1 | Block can take a word (low while forwarding) |
| in_first | input | 1 | Word is the header of a packet |
| in_last | input | 1 | Word is the CRC closing a packet |
| in_data | input | 32 | Incoming word |
| out_valid | output | 1 | Forwarded word is present |
| out_ready | input | 1 | Upper layer takes the word |
| out_data | output | 32 | Forwarded header or payload word |
| out_last | output | 1 | Final word of a forwarded packet |
| ack_req | output | 1 | One-cycle request for a positive acknowledgement |
| ack_seq | output | 12 | Sequence number for the positive acknowledgement |
| nak_req | output | 1 | One-cycle request for a negative acknowledgement |
| nak_seq | output | 12 | Number from which retransmission must start |

## Verification
The assertions assume the input is properly framed. `in_first` marks only the opening word of a packet, and `in_last` closes every packet before the next one opens. The single-pulse property also relies on each packet taking at least two beats. The one exception is the deliberate single-beat malformed case, which is sent only while a negative acknowledgement is already pending or on its own. The stimulus task builds each packet as header, payload and check word. It raises `in_first` and `in_last` only on the opening and closing beats, and it waits for `in_ready` before every beat. Idle gaps and random `out_ready` stalls vary the timing without breaking the framing.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

  typedef enum logic [1:0] {VD_NONE, VD_ACCEPT, VD_DUP, VD_NAK} verdict_e;

  // One word folded into a running CRC, least significant bit first.
  function automatic logic [31:0] crc32_word(input logic [31:0] c_in,
                                             input logic [31:0] d);
    logic [31:0] r;
    r = c_in;
    for (int i = 0; i < 32; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/lrsc_crc_accum.sv
module lrsc_crc_accum
  import lrsc_pkg::*;
#(
  parameter int unsigned SEQ_W = 12,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 2),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              first,
  input  logic              last,
  input  logic [WORD_W-1:0] data,
  output logic              body_good,
  output logic [SEQ_W-1:0]  seq_o,
  output logic [CNT_W-1:0]  body_len,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx
);
  logic [31:0]      crc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEQ_W-1:0] seq_q;
  logic             crc_ok, len_ok;

  always_comb begin
    crc_ok    = (crc_q ^ CRC_SEED) == data;
    len_ok    = !first && (cnt_q != '0) && (cnt_q <= CNT_W'(DEPTH));
    body_good = crc_ok && len_ok;
    wr_en     = beat && !last && (first || (cnt_q < CNT_W'(DEPTH)));
    wr_idx    = first ? '0 : cnt_q[IDX_W-1:0];
    seq_o     = seq_q;
    body_len  = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
      cnt_q <= '0;
      seq_q <= '0;
    end else if (beat && !last) begin
      crc_q <= crc32_word(first ? CRC_SEED : crc_q, data);
      if (first) begin
        cnt_q <= CNT_W'(1);
        seq_q <= data[SEQ_W-1:0];
      end else if (cnt_q != CNT_W'(DEPTH + 1)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH + 1));  // R9
endmodule

// File: rtl/lrsc_verdict.sv
module lrsc_verdict
  import lrsc_pkg::*;
#(
  parameter int unsigned SEQ_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             good,
  input  logic [SEQ_W-1:0] seq,
  output logic             accept,
  output logic             ack_req,
  output logic [SEQ_W-1:0] ack_seq,
  output logic             nak_req,
  output logic [SEQ_W-1:0] nak_seq
);
  logic [SEQ_W-1:0] exp_q, exp_m1;
  logic             pend_q;
  verdict_e         vd;

  always_comb begin
    exp_m1 = exp_q - 1'b1;
    if (!done)                       vd = VD_NONE;
    else if (good && seq == exp_q)   vd = VD_ACCEPT;
    else if (good && seq == exp_m1)  vd = VD_DUP;
    else if (!pend_q)                vd = VD_NAK;
    else                             vd = VD_NONE;
    accept = (vd == VD_ACCEPT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q   <= '0;
      pend_q  <= 1'b0;
      ack_req <= 1'b0;
      ack_seq <= '0;
      nak_req <= 1'b0;
      nak_seq <= '0;
    end else begin
      ack_req <= (vd == VD_ACCEPT) || (vd == VD_DUP);
      nak_req <= (vd == VD_NAK);
      if (vd == VD_ACCEPT) begin
        ack_seq <= exp_q;
        exp_q   <= exp_q + 1'b1;
        pend_q  <= 1'b0;
      end else if (vd == VD_DUP) begin
        ack_seq <= exp_m1;
      end else if (vd == VD_NAK) begin
        nak_seq <= exp_q;
        pend_q  <= 1'b1;
      end
    end
  end

  AST_EXP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> exp_q == $past(exp_q));  // R4
  AST_EXP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> exp_q == SEQ_W'($past(exp_q) + 1'b1));  // R4
  AST_NAK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !accept) |=> !nak_req);  // R7
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_req && nak_req));  // R11
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> !ack_req);  // R11
endmodule

// File: rtl/lrsc_fwd_buf.sv
module lrsc_fwd_buf
  import lrsc_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 2),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_len,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              busy
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  rd_q;
  logic [CNT_W-1:0]  len_q;
  logic              busy_q;

  always_comb begin
    busy      = busy_q;
    out_valid = busy_q;
    out_data  = mem_q[rd_q];
    out_last  = (CNT_W'(rd_q) == len_q - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= '0;
      len_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      rd_q   <= '0;
      len_q  <= start_len;
    end else if (busy_q && out_ready) begin
      if (out_last) busy_q <= 1'b0;
      else          rd_q   <= rd_q + 1'b1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));  // R10
endmodule

// File: rtl/link_rx_seq_check.sv
module link_rx_seq_check
  import lrsc_pkg::*;
#(
  parameter int unsigned SEQ_W = 12,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 2),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              ack_req,
  output logic [SEQ_W-1:0]  ack_seq,
  output logic              nak_req,
  output logic [SEQ_W-1:0]  nak_seq
);
  logic             busy, beat, pkt_done, body_good, accept, wr_en;
  logic [SEQ_W-1:0] hdr_seq;
  logic [CNT_W-1:0] body_len;
  logic [IDX_W-1:0] wr_idx;

  assign in_ready = !busy;
  assign beat     = in_valid && in_ready;
  assign pkt_done = beat && in_last;

  lrsc_crc_accum #(.SEQ_W(SEQ_W), .DEPTH(DEPTH)) u_accum (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(in_first), .last(in_last),
    .data(in_data), .body_good(body_good), .seq_o(hdr_seq), .body_len(body_len),
    .wr_en(wr_en), .wr_idx(wr_idx)
  );

  lrsc_verdict #(.SEQ_W(SEQ_W)) u_verdict (
    .clk(clk), .rst_n(rst_n), .done(pkt_done), .good(body_good), .seq(hdr_seq),
    .accept(accept), .ack_req(ack_req), .ack_seq(ack_seq),
    .nak_req(nak_req), .nak_seq(nak_seq)
  );

  lrsc_fwd_buf #(.DEPTH(DEPTH)) u_fwd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(in_data),
    .start(accept), .start_len(body_len), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .busy(busy)
  );

  AST_FWD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready && in_last));  // R3
  AST_ACK_WITH_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ack_req);  // R3
endmodule

// File: tb/link_rx_seq_check_bench.sv
module link_rx_seq_check_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, out_last, ack_req, nak_req;
  logic [31:0] out_data;
  logic [11:0] ack_seq, nak_seq;

  always #5 clk = ~clk;

  link_rx_seq_check #(.SEQ_W(12), .DEPTH(DEPTH)) u_link_rx_seq_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .ack_req(ack_req), .ack_seq(ack_seq),
    .nak_req(nak_req), .nak_seq(nak_seq)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] w[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (w[i])
      for (int b = 0; b < 4; b++) begin
        c ^= {24'h0, w[i][8*b +: 8]};
        for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
    return ~c;
  endfunction

  // behavioural reference model
  logic [31:0] cur[$];
  logic [31:0] fq[$];
  int  m_exp = 0;
  bit  m_pend = 0, m_drain = 0, m_ack = 0, m_nak = 0;
  int  m_ack_seq = 0, m_nak_seq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_exp = 0; m_pend = 0; m_drain = 0; m_ack = 0; m_nak = 0;
      cur.delete(); fq.delete();
    end else begin
      m_ack = 0; m_nak = 0;
      if (m_drain) begin
        if (out_ready) begin
          void'(fq.pop_front());
          if (fq.size() == 0) m_drain = 0;
        end
      end else if (in_valid) begin
        if (in_first) cur.delete();
        cur.push_back(in_data);
        if (in_last) begin
          logic [31:0] body[$];
          bit ok;
          int s;
          body = cur[0:$-1];
          ok = (cur.size() >= 2) && (body.size() <= DEPTH) && !(in_first) &&
               (ref_crc(body) == cur[$]);
          s = ok ? int'(body[0][11:0]) : -1;
          if (ok && s == m_exp) begin
            m_ack = 1; m_ack_seq = m_exp; fq = body; m_drain = 1;
            m_exp = (m_exp + 1) % 4096; m_pend = 0;
          end else if (ok && s == (m_exp + 4095) % 4096) begin
            m_ack = 1; m_ack_seq = (m_exp + 4095) % 4096;
          end else if (!m_pend) begin
            m_nak = 1; m_nak_seq = m_exp; m_pend = 1;
          end
          cur.delete();
        end
      end
    end
  end

  // DUT-side event counters (values before each edge)
  int ack_cnt = 0, nak_cnt = 0, fwd_cnt = 0, last_ack = -1, last_nak = -1;
  always @(posedge clk) if (rst_n) begin
    if (ack_req) begin ack_cnt++; last_ack = ack_seq; end
    if (nak_req) begin nak_cnt++; last_nak = nak_seq; end
    if (out_valid && out_ready) fwd_cnt++;
  end

  // cycle-by-cycle comparison
  always @(negedge clk) if (rst_n && !finished) begin
    chk(in_ready == !m_drain, "R10", "in_ready", in_ready, !m_drain);
    chk(!(out_valid && in_ready), "R10", "in_ready while forwarding", in_ready, 0);
    chk(out_valid == m_drain, "R3", "out_valid", out_valid, m_drain);
    if (m_drain && out_valid) begin
      chk(out_data == fq[0], "R3", "out_data", out_data, fq[0]);
      chk(out_last == (fq.size() == 1), "R3", "out_last", out_last, fq.size() == 1);
    end
    chk(ack_req == m_ack, "R3", "ack_req", ack_req, m_ack);
    if (m_ack) chk(ack_seq == m_ack_seq, "R3", "ack_seq", ack_seq, m_ack_seq);
    chk(nak_req == m_nak, "R5", "nak_req", nak_req, m_nak);
    if (m_nak) chk(nak_seq == m_nak_seq, "R5", "nak_seq", nak_seq, m_nak_seq);
    chk(!(ack_req && nak_req), "R11", "ack and nak together", ack_req & nak_req, 0);
  end

  initial begin
    forever begin
      @(negedge clk);
      out_ready = ($urandom % 3) != 0;
    end
  end

  // mode 0 good, 1 corrupt CRC; nbody 0 gives a single-beat packet
  task automatic send_pkt(input int seq, input int nbody, input int mode, input bit gaps);
    logic [31:0] w[$];
    if (nbody > 0) begin
      w.push_back({$urandom() % (1 << 20), 12'(seq)});
      for (int i = 1; i < nbody; i++) w.push_back($urandom());
    end
    w.push_back(ref_crc(w) ^ (mode == 1 ? 32'h0000_0100 : 32'h0));
    for (int i = 0; i < w.size(); i++) begin
      @(negedge clk);
      if (gaps && ($urandom % 4 == 0)) begin in_valid = 1'b0; @(negedge clk); end
      while (!in_ready) begin in_valid = 1'b0; @(negedge clk); end
      in_valid = 1'b1; in_first = (i == 0); in_last = (i == w.size() - 1);
      in_data = w[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic settle();
    repeat (DEPTH * 4 + 4) @(negedge clk);
    #1;
  endtask

  int a0, n0, f0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
    chk(!out_valid && !ack_req && !nak_req, "R1", "outputs idle after reset",
        {out_valid, ack_req, nak_req}, 0);

    // R3 in-order packets of every legal length
    for (int s = 0; s < DEPTH; s++) send_pkt(s, s + 1, 0, 1);
    settle();
    chk(ack_cnt == DEPTH, "R3", "ack count", ack_cnt, DEPTH);
    chk(last_ack == DEPTH - 1, "R3", "last ack seq", last_ack, DEPTH - 1);
    chk(fwd_cnt == DEPTH * (DEPTH + 1) / 2, "R3", "forwarded words", fwd_cnt,
        DEPTH * (DEPTH + 1) / 2);
    chk(nak_cnt == 0, "R2", "good CRC gives no nak", nak_cnt, 0);

    // R2 / R5 corrupted packet
    a0 = ack_cnt; f0 = fwd_cnt;
    send_pkt(8, 3, 1, 0); settle();
    chk(nak_cnt == 1, "R2", "corrupt CRC detected", nak_cnt, 1);
    chk(last_nak == 8, "R5", "nak seq", last_nak, 8);
    chk(fwd_cnt == f0 && ack_cnt == a0, "R5", "nothing forwarded", fwd_cnt, f0);

    // R7 silence while pending
    send_pkt(9, 2, 0, 0); send_pkt(8, 2, 1, 0); send_pkt(30, 1, 0, 0);
    settle();
    chk(nak_cnt == 1, "R7", "no extra nak while pending", nak_cnt, 1);
    chk(fwd_cnt == f0, "R7", "nothing forwarded while pending", fwd_cnt, f0);

    // R8 duplicate while pending, then recovery
    n0 = nak_cnt;
    send_pkt(7, 2, 0, 0); settle();
    chk(ack_cnt == a0 + 1 && last_ack == 7, "R8", "dup ack while pending", last_ack, 7);
    chk(fwd_cnt == f0, "R8", "dup not forwarded", fwd_cnt, f0);
    send_pkt(8, 4, 0, 1); settle();
    chk(last_ack == 8 && fwd_cnt == f0 + 4, "R7", "recovery accepted", last_ack, 8);
    f0 = fwd_cnt;
    send_pkt(8, 2, 0, 0); settle();
    chk(last_ack == 8 && fwd_cnt == f0 && nak_cnt == n0, "R8", "replayed copy acked",
        last_ack, 8);

    // R6 out-of-range number
    send_pkt(20, 2, 0, 0); settle();
    chk(nak_cnt == n0 + 1 && last_nak == 9, "R6", "out-of-range nak", last_nak, 9);
    chk(fwd_cnt == f0, "R6", "out-of-range dropped", fwd_cnt, f0);

    // R9 malformed lengths
    send_pkt(9, 2, 0, 0); settle();
    n0 = nak_cnt;
    send_pkt(10, DEPTH + 1, 0, 0); settle();
    chk(nak_cnt == n0 + 1 && last_nak == 10, "R9", "overlong packet nak", last_nak, 10);
    send_pkt(10, 2, 0, 0); settle();
    n0 = nak_cnt;
    send_pkt(11, 0, 0, 0); settle();
    chk(nak_cnt == n0 + 1 && last_nak == 11, "R9", "single-beat packet nak", last_nak, 11);
    send_pkt(11, 1, 0, 0); settle();
    chk(last_ack == 11, "R9", "recovery after malformed", last_ack, 11);

    // R4 wrap of the sequence space
    for (int s = 12; s < 4096; s++) send_pkt(s, 1, 0, 0);
    settle();
    chk(last_ack == 4095, "R4", "reach 4095", last_ack, 4095);
    send_pkt(0, 2, 0, 0); settle();
    chk(last_ack == 0, "R4", "wrap to 0", last_ack, 0);
    send_pkt(0, 2, 0, 0); settle();
    chk(last_ack == 0, "R8", "dup after wrap", last_ack, 0);
    a0 = ack_cnt;
    send_pkt(4095, 2, 0, 0); settle();
    chk(ack_cnt == a0 && last_nak == 1, "R4", "stale 4095 rejected after wrap", last_nak, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule